// File: doc/BRIEF.md
# Early-Lookup Cache Bank Front End

This block is the request side of one bank in a banked, set-associative cache. A request address reaches the bank as a short burst of narrow flits on a valid/ready channel. The bank does not wait for the whole address. The first flit carries the set index, so that flit alone starts the read of every way of the set. The tag and data array read then runs while the later flits are still on their way.

The upper address bits are needed only for the tag compare. Once the last flit has been taken, the bank compares the tags of all ways and picks at most one matching way. On a hit it streams the line back as a run of wide data flits; on a miss it returns a single miss flit.

Writes also send their address as a burst of flits, but they change nothing until the full address is present. A write then updates the matching way, or it allocates a way if no way matches. Only one request is in service at a time: the address channel is held off while a lookup or a response is in progress.

Top module: `elk_bank`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and every line of every set is invalid, so any read misses.
- R2: An address is taken as four 16-bit flits, least significant first: flit 0 is addr[15:0] and flit 3 is addr[63:48]. `req_ready` is 0 from the cycle after the fourth flit is accepted until the cycle after the final response flit.
- R3: The set index is addr[9:6], which lies in flit 0. The tag is addr[63:10]. Byte offset addr[5:0] plays no part in the lookup. The result does not depend on idle gaps between the flits.
- R4: A read hit returns four 128-bit flits on consecutive cycles. The first flit carries line bits [127:0], `rsp_miss` is 0, and `rsp_last` is 1 only on the fourth flit. The first flit is valid in the second cycle after the last address flit is accepted.
- R5: A read miss returns exactly one flit with `rsp_miss`=1, `rsp_data`=0 and `rsp_last`=1.
- R6: `req_write` is sampled with flit 0 and `wr_line` with flit 3. The arrays change only after all four flits have arrived. A write answers with one flit: `rsp_miss`=0, `rsp_data`=0, `rsp_last`=1.
- R7: A write whose tag already sits in the set overwrites that way in place, and a later read returns the new line.
- R8: A write that misses fills the lowest-numbered invalid way of the set. If every way is valid, it replaces way (tag mod 4).
- R9: Sets are independent: a line written into one set is not found under the same tag with a different index.
- R10: While `req_ready` is 0, activity on `req_valid`, `req_flit` and `req_write` has no effect on the response in progress or on the stored lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address flit valid |
| req_ready | output | 1 | Bank can take an address flit |
| req_flit | input | 16 | Address flit |
| req_write | input | 1 | Request is a write (taken with flit 0) |
| wr_line | input | 512 | Write line (taken with flit 3) |
| rsp_valid | output | 1 | Response flit valid |
| rsp_data | output | 128 | Response data flit |
| rsp_miss | output | 1 | Read found no matching way |
| rsp_last | output | 1 | Final flit of the response |

## Verification
The one-hot check on way matches assumes that the requester never places the same tag twice in a set by any path other than this block's own write handling. The bench satisfies this because it stores lines only through the block's write requests.

The response assertions assume that the consumer always accepts data, since the data channel has no stall. The bench therefore samples every flit in the cycle it appears.

The bench drives flits only while `req_ready` is high, apart from a deliberate run in which junk stays on the channel during a busy period to show that it is ignored. It also lowers `req_valid` in the same cycle that the final response flit appears.

// File: rtl/elk_pkg.sv
package elk_pkg;
   typedef enum logic [1:0] {
      ST_ACCEPT = 2'd0,
      ST_LOOK   = 2'd1,
      ST_RESP   = 2'd2
   } elk_state_e;
endpackage

// File: rtl/elk_flit_asm.sv
// Reassembles a multi-flit address; flags the index-carrying first flit.
module elk_flit_asm #(
   parameter int ADDR_W = 64,
   parameter int FLIT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [FLIT_W-1:0] flit,
   input  logic              wr_in,
   output logic              first,
   output logic              done,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_q
);
   localparam int NFLIT = ADDR_W / FLIT_W;
   localparam int CNT_W = (NFLIT > 1) ? $clog2(NFLIT) : 1;

   if (NFLIT < 2 || NFLIT * FLIT_W != ADDR_W) begin : g_bad_split
      $error("address must split into two or more whole flits");
   end

   logic [CNT_W-1:0] cnt_q;

   assign first = fire && (cnt_q == '0);
   assign done  = fire && (cnt_q == CNT_W'(NFLIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         addr  <= '0;
         wr_q  <= 1'b0;
      end else if (fire) begin
         addr[cnt_q*FLIT_W +: FLIT_W] <= flit;
         cnt_q <= done ? '0 : cnt_q + 1'b1;
         if (first) wr_q <= wr_in;
      end
   end

   // R2: the flit counter never wraps without completing an address
   a_r2_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !done) |=> (cnt_q != '0));
endmodule

// File: rtl/elk_way_array.sv
// Per-way tag, valid and line storage with a registered set read.
module elk_way_array #(
   parameter int SETS   = 16,
   parameter int WAYS   = 4,
   parameter int TAG_W  = 54,
   parameter int LINE_W = 512
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_en,
   input  logic [$clog2(SETS)-1:0]       rd_idx,
   input  logic                          we,
   input  logic [$clog2(WAYS)-1:0]       wr_way,
   input  logic [$clog2(SETS)-1:0]       wr_idx,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic [LINE_W-1:0]             wr_line,
   output logic [WAYS-1:0]               rd_vld,
   output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
   output logic [WAYS-1:0][LINE_W-1:0]   rd_line
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]  tmem [SETS];
      logic [LINE_W-1:0] dmem [SETS];
      logic [SETS-1:0]   vmem;
      logic              vld_r;
      logic [TAG_W-1:0]  tag_r;
      logic [LINE_W-1:0] line_r;
      logic              sel;

      assign sel = we && (wr_way == w[$clog2(WAYS)-1:0]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vmem  <= '0;
            vld_r <= 1'b0;
         end else begin
            if (sel) vmem[wr_idx] <= 1'b1;
            if (rd_en) vld_r <= vmem[rd_idx];
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tmem[wr_idx] <= wr_tag;
            dmem[wr_idx] <= wr_line;
         end
         if (rd_en) begin
            tag_r  <= tmem[rd_idx];
            line_r <= dmem[rd_idx];
         end
      end

      assign rd_vld[w]  = vld_r;
      assign rd_tag[w]  = tag_r;
      assign rd_line[w] = line_r;
   end
endmodule

// File: rtl/elk_tag_sel.sv
// Full tag compare across ways plus victim choice for write misses.
module elk_tag_sel #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 54
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WAYS-1:0]            rd_vld,
   input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
   input  logic [TAG_W-1:0]           req_tag,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit,
   output logic [$clog2(WAYS)-1:0]    hit_way,
   output logic [$clog2(WAYS)-1:0]    victim_way
);
   localparam int WAY_W = $clog2(WAYS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == req_tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way    = '0;
      victim_way = req_tag[WAY_W-1:0];
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
         if (!rd_vld[w]) victim_way = WAY_W'(w);
      end
   end

   // R4: at most one way may match a given tag
   a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/elk_bank.sv
module elk_bank
   import elk_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int FLIT_W = 16,
   parameter int LINE_W = 512,
   parameter int DATA_W = 128,
   parameter int WAYS   = 4,
   parameter int SETS   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [FLIT_W-1:0] req_flit,
   input  logic              req_write,
   input  logic [LINE_W-1:0] wr_line,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_miss,
   output logic              rsp_last
);
   localparam int OFF_W  = $clog2(LINE_W / 8);
   localparam int IDX_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int NBEAT  = LINE_W / DATA_W;
   localparam int BEAT_W = (NBEAT > 1) ? $clog2(NBEAT) : 1;

   if (OFF_W + IDX_W > FLIT_W) begin : g_bad_index
      $error("set index must fit inside the first address flit");
   end
   if (NBEAT < 2 || NBEAT * DATA_W != LINE_W) begin : g_bad_beats
      $error("line must split into two or more whole data flits");
   end

   elk_state_e state_q;
   logic fire, asm_first, asm_done, asm_wr;
   logic [ADDR_W-1:0] asm_addr;
   logic [LINE_W-1:0] wr_line_q;
   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [WAYS-1:0]   rd_vld, hit_vec;
   logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
   logic [WAYS-1:0][LINE_W-1:0] rd_line;
   logic hit, arr_we;
   logic [WAY_W-1:0] hit_way, victim_way, wr_way;
   logic [LINE_W-1:0] sel_line_q;
   logic [BEAT_W-1:0] beat_q, last_beat_q;
   logic data_en_q, miss_q;

   assign req_ready = (state_q == ST_ACCEPT);
   assign fire      = req_valid && req_ready;

   elk_flit_asm #(.ADDR_W(ADDR_W), .FLIT_W(FLIT_W)) u_asm (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .flit  (req_flit),
      .wr_in (req_write),
      .first (asm_first),
      .done  (asm_done),
      .addr  (asm_addr),
      .wr_q  (asm_wr)
   );

   assign req_tag = asm_addr[ADDR_W-1 -: TAG_W];
   assign req_idx = asm_addr[OFF_W +: IDX_W];

   // Early lookup: set read launched straight from the first flit
   elk_way_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (asm_first),
      .rd_idx  (req_flit[OFF_W +: IDX_W]),
      .we      (arr_we),
      .wr_way  (wr_way),
      .wr_idx  (req_idx),
      .wr_tag  (req_tag),
      .wr_line (wr_line_q),
      .rd_vld  (rd_vld),
      .rd_tag  (rd_tag),
      .rd_line (rd_line)
   );

   elk_tag_sel #(.WAYS(WAYS), .TAG_W(TAG_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_vld     (rd_vld),
      .rd_tag     (rd_tag),
      .req_tag    (req_tag),
      .hit_vec    (hit_vec),
      .hit        (hit),
      .hit_way    (hit_way),
      .victim_way (victim_way)
   );

   assign arr_we = (state_q == ST_LOOK) && asm_wr;
   assign wr_way = hit ? hit_way : victim_way;

   always_ff @(posedge clk) begin
      if (asm_done) wr_line_q <= wr_line;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_ACCEPT;
         beat_q      <= '0;
         last_beat_q <= '0;
         data_en_q   <= 1'b0;
         miss_q      <= 1'b0;
         sel_line_q  <= '0;
      end else begin
         unique case (state_q)
            ST_ACCEPT: if (asm_done) state_q <= ST_LOOK;
            ST_LOOK: begin
               state_q <= ST_RESP;
               beat_q  <= '0;
               if (asm_wr) begin
                  last_beat_q <= '0;
                  data_en_q   <= 1'b0;
                  miss_q      <= 1'b0;
               end else if (hit) begin
                  last_beat_q <= BEAT_W'(NBEAT - 1);
                  data_en_q   <= 1'b1;
                  miss_q      <= 1'b0;
                  sel_line_q  <= rd_line[hit_way];
               end else begin
                  last_beat_q <= '0;
                  data_en_q   <= 1'b0;
                  miss_q      <= 1'b1;
               end
            end
            ST_RESP: begin
               if (beat_q == last_beat_q) state_q <= ST_ACCEPT;
               else beat_q <= beat_q + 1'b1;
            end
            default: state_q <= ST_ACCEPT;
         endcase
      end
   end

   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_last  = rsp_valid && (beat_q == last_beat_q);
   assign rsp_miss  = rsp_valid && miss_q;
   assign rsp_data  = (rsp_valid && data_en_q) ? sel_line_q[beat_q*DATA_W +: DATA_W] : '0;

   // R6: arrays are written only right after the final address flit
   a_r6_write_after_full: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> $past(asm_done));
   // R2: the channel closes as soon as an address is complete
   a_r2_close_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
      asm_done |=> !req_ready);
   // R4: a multi-flit response runs without gaps
   a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_last) |=> rsp_valid);
   // R5: a miss is one empty flit
   a_r5_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_last && rsp_data == '0));
   // R10: nothing is taken from the channel while a response is out
   a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !fire);
endmodule

// File: tb/sim_elk_bank.sv
`timescale 1ns/1ps
module sim_elk_bank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [15:0] req_flit = '0;
   logic req_write = 1'b0;
   logic [511:0] wr_line = '0;
   logic rsp_valid;
   logic [127:0] rsp_data;
   logic rsp_miss, rsp_last;

   int nchk = 0;
   int nfail = 0;

   logic [127:0] got [8];
   int  got_n;
   logic got_miss;

   always #4 clk = ~clk;

   elk_bank u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_flit(req_flit), .req_write(req_write), .wr_line(wr_line),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_miss(rsp_miss), .rsp_last(rsp_last)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mkaddr(input logic [53:0] tag, input logic [3:0] idx, input logic [5:0] off);
      return {tag, idx, off};
   endfunction

   function automatic logic [511:0] mkline(input int s);
      logic [511:0] l;
      for (int b = 0; b < 4; b++) l[b*128 +: 128] = {32'hC0DE0000 + 32'(s), 32'(s), 32'(b), 32'h5A5A5A5A};
      return l;
   endfunction

   // Drive one request and gather its response flits.
   task automatic run_req(input logic [63:0] addr, input bit wr, input logic [511:0] line,
                          input int gap, input bit junk);
      for (int i = 0; i < 4; i++) begin
         if (i > 0) begin
            repeat (gap) begin
               @(negedge clk);
               req_valid = 1'b0;
            end
         end
         @(negedge clk);
         chk(req_ready == 1'b1, "R2 ready while collecting", 128'(req_ready), 128'd1);
         req_valid = 1'b1;
         req_flit  = addr[i*16 +: 16];
         req_write = (i == 0) ? wr : ~wr;
         wr_line   = (i == 3) ? line : ~line;
         @(posedge clk);
      end
      @(negedge clk);
      req_valid = junk;
      req_flit  = 16'hDEAD;
      req_write = 1'b1;
      wr_line   = '1;
      chk(req_ready == 1'b0, "R2 ready drops after last flit", 128'(req_ready), 128'd0);
      chk(rsp_valid == 1'b0, "R4 no response during compare", 128'(rsp_valid), 128'd0);
      got_n = 0;
      got_miss = 1'b0;
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R4 response two cycles after last flit", 128'(rsp_valid), 128'd1);
      for (int k = 0; k < 8; k++) begin
         if (!rsp_valid) break;
         chk(req_ready == 1'b0, "R10 channel closed during response", 128'(req_ready), 128'd0);
         got[got_n] = rsp_data;
         got_miss = rsp_miss;
         got_n++;
         if (rsp_last) begin
            req_valid = 1'b0;
            break;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   task automatic do_read(input logic [63:0] addr, input bit exp_hit, input logic [511:0] line,
                          input int gap, input bit junk, input string req);
      run_req(addr, 1'b0, '0, gap, junk);
      if (exp_hit) begin
         chk(got_n == 4, {req, " hit flit count"}, 128'(got_n), 128'd4);
         chk(got_miss == 1'b0, {req, " hit miss flag"}, 128'(got_miss), 128'd0);
         for (int b = 0; b < 4; b++)
            chk(got[b] === line[b*128 +: 128], {req, " R4 hit data beat"}, got[b], line[b*128 +: 128]);
      end else begin
         chk(got_n == 1, {req, " R5 miss flit count"}, 128'(got_n), 128'd1);
         chk(got_miss == 1'b1, {req, " R5 miss flag"}, 128'(got_miss), 128'd1);
         chk(got[0] === '0, {req, " R5 miss data zero"}, got[0], 128'd0);
      end
   endtask

   task automatic do_write(input logic [63:0] addr, input logic [511:0] line, input int gap);
      run_req(addr, 1'b1, line, gap, 1'b0);
      chk(got_n == 1, "R6 write ack flit count", 128'(got_n), 128'd1);
      chk(got_miss == 1'b0, "R6 write ack miss flag", 128'(got_miss), 128'd0);
      chk(got[0] === '0, "R6 write ack data", got[0], 128'd0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 128'(req_ready), 128'd1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", 128'(rsp_valid), 128'd0);
      do_read(mkaddr(54'd5, 4'd3, 6'd0), 1'b0, '0, 0, 1'b0, "R1 empty read");
   endtask

   task automatic t_write_read;
      do_write(mkaddr(54'd5, 4'd3, 6'd0), mkline(1), 0);
      do_read(mkaddr(54'd5, 4'd3, 6'd0), 1'b1, mkline(1), 0, 1'b0, "R4 read after write");
      do_read(mkaddr(54'd5, 4'd3, 6'd37), 1'b1, mkline(1), 3, 1'b0, "R3 gapped flits, other offset");
   endtask

   task automatic t_overwrite;
      do_write(mkaddr(54'd5, 4'd3, 6'd0), mkline(2), 2);
      do_read(mkaddr(54'd5, 4'd3, 6'd0), 1'b1, mkline(2), 0, 1'b0, "R7 overwrite in place");
   endtask

   task automatic t_sets;
      do_read(mkaddr(54'd5, 4'd4, 6'd0), 1'b0, '0, 0, 1'b0, "R9 other set misses");
      do_read(mkaddr(54'd6, 4'd3, 6'd0), 1'b0, '0, 1, 1'b0, "R3 other tag misses");
   endtask

   task automatic t_evict;
      // set 7: tags 8..11 fill ways 0..3, tag 13 (13 mod 4 = 1) replaces tag 9
      for (int t = 8; t < 12; t++) do_write(mkaddr(54'(t), 4'd7, 6'd0), mkline(100 + t), 0);
      do_read(mkaddr(54'd11, 4'd7, 6'd0), 1'b1, mkline(111), 0, 1'b0, "R8 fourth way filled");
      do_write(mkaddr(54'd13, 4'd7, 6'd0), mkline(113), 0);
      do_read(mkaddr(54'd9, 4'd7, 6'd0), 1'b0, '0, 0, 1'b0, "R8 victim way evicted");
      do_read(mkaddr(54'd8, 4'd7, 6'd0), 1'b1, mkline(108), 0, 1'b0, "R8 way0 kept");
      do_read(mkaddr(54'd10, 4'd7, 6'd0), 1'b1, mkline(110), 0, 1'b0, "R8 way2 kept");
      do_read(mkaddr(54'd13, 4'd7, 6'd0), 1'b1, mkline(113), 0, 1'b0, "R8 new line present");
   endtask

   task automatic t_busy;
      do_read(mkaddr(54'd5, 4'd3, 6'd0), 1'b1, mkline(2), 0, 1'b1, "R10 junk during response");
      do_read(mkaddr(54'd13, 4'd7, 6'd0), 1'b1, mkline(113), 0, 1'b1, "R10 line unchanged after junk");
   endtask

   initial begin
      #400000;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_read();
      t_overwrite();
      t_sets();
      t_evict();
      t_busy();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule